// File: doc/BRIEF.md
# Prioritized Interrupt Vectoring Controller

This block decides, once per machine cycle, whether the processor should leave its current instruction stream and enter an interrupt service routine, and which of twelve request sources gets served. Raw request flags are frozen by a capture strobe late in each machine cycle. A poll strobe in the following machine cycle evaluates the frozen copy. Each source is gated by its own enable bit and by one global enable bit.

Sources are arranged in six pairs. Each pair takes one bit from a low priority register and one bit from a high priority register, which gives four levels. Level 3 is the most urgent. The highest level among eligible sources wins. A fixed source order is used only when several sources share the winning level.

A call is only issued in the final cycle of an instruction. No call is issued when that instruction is a return from interrupt or writes an interrupt configuration register. No call is issued when a level equal to or above the winner's level is still in service. For each call the block marks the winner's level as in service and emits a one-cycle call pulse, the source index, the level and a vector address. A return from interrupt clears the highest in-service level.

Top module: `irq_vector_ctrl`

## Requirements
- R1: The poll uses only the flag values captured at the most recent clock with `capture_stb_i` high. A raw flag that was never captured produces no call.
- R2: A poll that is not blocked raises `call_o` for exactly one clock, in the clock after the poll strobe. With the call, `src_o` gives the winner index, `lvl_o` gives its level and `vec_o` equals VEC_BASE + 8 × index (defaults: base 3).
- R3: Source i has level {prio_hi_i[i/2], prio_lo_i[i/2]}. A source at a higher level wins over any source at a lower level, whatever their fixed order.
- R4: Among eligible sources at the winning level, the lowest index wins. The index order, most urgent first, is: 0 external 0, 1 converter done, 2 timer 0, 3 external 2, 4 external 1, 5 external 3, 6 timer 1, 7 external 4, 8 serial, 9 external 5, 10 timer 2, 11 external 6.
- R5: A call is issued only if the winner's level is strictly above every level currently in service.
- R6: No call is issued at a poll where `last_cycle_i` is low.
- R7: No call is issued at a poll where `reti_i` or `cfg_wr_i` is high.
- R8: Each call marks its level as in service. A poll with `last_cycle_i` and `reti_i` both high clears only the highest in-service level.
- R9: A source takes part in the poll only when `glb_en_i` is high and its own `src_en_i` bit is high.
- R10: Reset drives `call_o`, `src_o`, `lvl_o` and `vec_o` to zero, clears the captured flags and clears every in-service level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 12 | Raw request flags, bit i = source i |
| capture_stb_i | input | 1 | Capture phase strobe, freezes `req_i` |
| poll_stb_i | input | 1 | Poll strobe, one clock per machine cycle |
| last_cycle_i | input | 1 | Current machine cycle ends the instruction |
| reti_i | input | 1 | Current instruction is a return from interrupt |
| cfg_wr_i | input | 1 | Current instruction writes an enable or priority register |
| glb_en_i | input | 1 | Global interrupt enable |
| src_en_i | input | 12 | Per-source enables |
| prio_lo_i | input | 6 | Low priority bit per source pair |
| prio_hi_i | input | 6 | High priority bit per source pair |
| call_o | output | 1 | One-clock service call request |
| src_o | output | 4 | Index of the served source |
| lvl_o | output | 2 | Level of the served source |
| vec_o | output | 16 | Service routine address |

## Verification
The captured flags change at the clock edge where the capture strobe is high. The call outputs are registered at the edge where the poll strobe is high, so they are valid one clock after the poll. Every poll the driver issues puts one expected record in a queue. A monitor wakes at the edge that samples the poll strobe and compares `call_o`, `src_o`, `lvl_o` and `vec_o` a quarter period later. After a call, the monitor also checks that `call_o` has dropped one clock later. Polls and captures are spaced several clocks apart, so each poll result and each in-service change settles before the next stimulus.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
    // Two priority register bits per source pair give four levels.
    localparam int unsigned LVL_W   = 2;
    localparam int unsigned NUM_LVL = 1 << LVL_W;

    typedef logic [LVL_W-1:0] irq_lvl_t;

    function automatic irq_lvl_t make_lvl(input logic hi, input logic lo);
        return {hi, lo};
    endfunction
endpackage

// File: rtl/irq_flag_sampler.sv
module irq_flag_sampler #(
    parameter int unsigned NUM_SRC = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cap_stb_i,
    input  logic [NUM_SRC-1:0] flags_i,
    output logic [NUM_SRC-1:0] smp_o
);
    logic [NUM_SRC-1:0] smp_d, smp_q;

    always_comb begin
        smp_d = smp_q;
        if (cap_stb_i) begin
            smp_d = flags_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_q <= '0;
        end else begin
            smp_q <= smp_d;
        end
    end

    assign smp_o = smp_q;
endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
    import irq_vec_pkg::*;
#(
    parameter int unsigned NUM_SRC  = 12,
    parameter int unsigned GRP_SIZE = 2,
    localparam int unsigned NUM_GRP = (NUM_SRC + GRP_SIZE - 1) / GRP_SIZE,
    localparam int unsigned IDX_W   = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] pend_i,
    input  logic [NUM_SRC-1:0] en_i,
    input  logic [NUM_GRP-1:0] prio_lo_i,
    input  logic [NUM_GRP-1:0] prio_hi_i,
    output logic               win_vld_o,
    output logic [IDX_W-1:0]   win_idx_o,
    output irq_lvl_t           win_lvl_o
);
    irq_lvl_t           src_lvl [NUM_SRC];
    logic [NUM_SRC-1:0] elig;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign src_lvl[g] = make_lvl(prio_hi_i[g / GRP_SIZE], prio_lo_i[g / GRP_SIZE]);
        assign elig[g]    = pend_i[g] & en_i[g];
    end

    // Scan from the least urgent index down; ">=" lets a lower index take ties.
    always_comb begin
        win_vld_o = 1'b0;
        win_idx_o = '0;
        win_lvl_o = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (elig[i] && (!win_vld_o || src_lvl[i] >= win_lvl_o)) begin
                win_vld_o = 1'b1;
                win_idx_o = IDX_W'(i);
                win_lvl_o = src_lvl[i];
            end
        end
    end
endmodule

// File: rtl/irq_insvc_tracker.sv
module irq_insvc_tracker
    import irq_vec_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_i,
    input  irq_lvl_t           set_lvl_i,
    input  logic               clr_top_i,
    output logic               any_o,
    output irq_lvl_t           top_lvl_o,
    output logic [NUM_LVL-1:0] insvc_o
);
    logic [NUM_LVL-1:0] insvc_d, insvc_q;

    always_comb begin
        any_o     = |insvc_q;
        top_lvl_o = '0;
        for (int l = 0; l < NUM_LVL; l++) begin
            if (insvc_q[l]) begin
                top_lvl_o = LVL_W'(l);
            end
        end
    end

    always_comb begin
        insvc_d = insvc_q;
        if (clr_top_i && any_o) begin
            insvc_d[top_lvl_o] = 1'b0;
        end
        if (set_i) begin
            insvc_d[set_lvl_i] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            insvc_q <= '0;
        end else begin
            insvc_q <= insvc_d;
        end
    end

    assign insvc_o = insvc_q;
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irq_vec_pkg::*;
#(
    parameter int unsigned NUM_SRC    = 12,
    parameter int unsigned GRP_SIZE   = 2,
    parameter int unsigned VEC_W      = 16,
    parameter int unsigned VEC_BASE   = 3,
    parameter int unsigned VEC_STRIDE = 8,
    localparam int unsigned NUM_GRP   = (NUM_SRC + GRP_SIZE - 1) / GRP_SIZE,
    localparam int unsigned IDX_W     = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req_i,
    input  logic               capture_stb_i,
    input  logic               poll_stb_i,
    input  logic               last_cycle_i,
    input  logic               reti_i,
    input  logic               cfg_wr_i,
    input  logic               glb_en_i,
    input  logic [NUM_SRC-1:0] src_en_i,
    input  logic [NUM_GRP-1:0] prio_lo_i,
    input  logic [NUM_GRP-1:0] prio_hi_i,
    output logic               call_o,
    output logic [IDX_W-1:0]   src_o,
    output logic [LVL_W-1:0]   lvl_o,
    output logic [VEC_W-1:0]   vec_o
);
    typedef struct packed {
        logic             call;
        logic [IDX_W-1:0] src;
        irq_lvl_t         lvl;
        logic [VEC_W-1:0] vec;
    } out_t;

    logic [NUM_SRC-1:0] smp_q;
    logic [NUM_SRC-1:0] en_eff;
    logic               win_vld;
    logic [IDX_W-1:0]   win_idx;
    irq_lvl_t           win_lvl;
    logic               is_any;
    irq_lvl_t           is_top;
    logic [NUM_LVL-1:0] insvc_q;
    logic               poll_end;
    logic               take;
    logic               ret_clr;
    out_t               out_d, out_q;

    irq_flag_sampler #(.NUM_SRC(NUM_SRC)) u_sampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_stb_i (capture_stb_i),
        .flags_i   (req_i),
        .smp_o     (smp_q)
    );

    assign en_eff = src_en_i & {NUM_SRC{glb_en_i}};

    irq_prio_arbiter #(.NUM_SRC(NUM_SRC), .GRP_SIZE(GRP_SIZE)) u_arb (
        .pend_i    (smp_q),
        .en_i      (en_eff),
        .prio_lo_i (prio_lo_i),
        .prio_hi_i (prio_hi_i),
        .win_vld_o (win_vld),
        .win_idx_o (win_idx),
        .win_lvl_o (win_lvl)
    );

    // Decision terms for this poll.
    always_comb begin
        poll_end = poll_stb_i & last_cycle_i;
        ret_clr  = poll_end & reti_i;
        take     = poll_end & ~reti_i & ~cfg_wr_i & win_vld
                 & (~is_any | (win_lvl > is_top));
    end

    irq_insvc_tracker u_insvc (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (take),
        .set_lvl_i (win_lvl),
        .clr_top_i (ret_clr),
        .any_o     (is_any),
        .top_lvl_o (is_top),
        .insvc_o   (insvc_q)
    );

    always_comb begin
        out_d      = out_q;
        out_d.call = take;
        if (take) begin
            out_d.src = win_idx;
            out_d.lvl = win_lvl;
            out_d.vec = VEC_W'(VEC_BASE) + VEC_W'(win_idx) * VEC_W'(VEC_STRIDE);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign call_o = out_q.call;
    assign src_o  = out_q.src;
    assign lvl_o  = out_q.lvl;
    assign vec_o  = out_q.vec;
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk
    import irq_vec_pkg::*;
#(
    parameter int unsigned NUM_SRC = 12,
    parameter int unsigned IDX_W   = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               poll_stb_i,
    input logic               last_cycle_i,
    input logic               reti_i,
    input logic               cfg_wr_i,
    input logic               glb_en_i,
    input logic               call_o,
    input logic [IDX_W-1:0]   src_o,
    input logic [LVL_W-1:0]   lvl_o,
    input logic [NUM_SRC-1:0] smp,
    input logic [NUM_LVL-1:0] insvc
);
    logic [NUM_SRC-1:0] smp_prev;
    logic [NUM_LVL-1:0] insvc_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_prev   <= '0;
            insvc_prev <= '0;
        end else begin
            smp_prev   <= smp;
            insvc_prev <= insvc;
        end
    end

    AST_CALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        call_o |=> !call_o); // R2
    AST_CALL_FROM_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        call_o |-> smp_prev[src_o]); // R1
    AST_CALL_ABOVE_INSVC: assert property (@(posedge clk) disable iff (!rst_n)
        call_o |-> ((insvc_prev >> lvl_o) == '0)); // R5
    AST_CALL_AT_LAST_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        call_o |-> $past(poll_stb_i && last_cycle_i)); // R6
    AST_CALL_NOT_RET_WR: assert property (@(posedge clk) disable iff (!rst_n)
        call_o |-> $past(!reti_i && !cfg_wr_i)); // R7
    AST_CALL_MARKS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        call_o |-> insvc[lvl_o]); // R8
    AST_CALL_GLOBAL_EN: assert property (@(posedge clk) disable iff (!rst_n)
        call_o |-> $past(glb_en_i)); // R9
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .poll_stb_i   (poll_stb_i),
    .last_cycle_i (last_cycle_i),
    .reti_i       (reti_i),
    .cfg_wr_i     (cfg_wr_i),
    .glb_en_i     (glb_en_i),
    .call_o       (call_o),
    .src_o        (src_o),
    .lvl_o        (lvl_o),
    .smp          (smp_q),
    .insvc        (insvc_q)
);

// File: tb/irq_vector_ctrl_test.sv
module irq_vector_ctrl_test;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] req = '0;
    logic        capture_stb = 1'b0;
    logic        poll_stb = 1'b0;
    logic        last_cycle = 1'b0;
    logic        reti = 1'b0;
    logic        cfg_wr = 1'b0;
    logic        glb_en = 1'b1;
    logic [11:0] src_en = 12'hFFF;
    logic [5:0]  prio_lo = '0;
    logic [5:0]  prio_hi = '0;
    logic        call_o;
    logic [3:0]  src_o;
    logic [1:0]  lvl_o;
    logic [15:0] vec_o;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    typedef struct {
        bit    call;
        int    idx;
        int    lvl;
        string tag;
    } exp_t;
    exp_t exp_q[$];

    always #(CLK_P/2) clk = ~clk;

    irq_vector_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .capture_stb_i(capture_stb),
        .poll_stb_i(poll_stb), .last_cycle_i(last_cycle), .reti_i(reti),
        .cfg_wr_i(cfg_wr), .glb_en_i(glb_en), .src_en_i(src_en),
        .prio_lo_i(prio_lo), .prio_hi_i(prio_hi), .call_o(call_o),
        .src_o(src_o), .lvl_o(lvl_o), .vec_o(vec_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic capture(input logic [11:0] r);
        @(negedge clk);
        req = r;
        capture_stb = 1'b1;
        @(negedge clk);
        capture_stb = 1'b0;
        req = '0;
        repeat (2) @(negedge clk);
    endtask

    // Driver: issues one poll and queues what it must produce.
    task automatic poll(input bit last, input bit ret, input bit wr,
                        input bit ecall, input int eidx, input int elvl, input string tag);
        exp_t e;
        @(negedge clk);
        e.call = ecall; e.idx = eidx; e.lvl = elvl; e.tag = tag;
        exp_q.push_back(e);
        poll_stb = 1'b1; last_cycle = last; reti = ret; cfg_wr = wr;
        @(negedge clk);
        poll_stb = 1'b0; last_cycle = 1'b0; reti = 1'b0; cfg_wr = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // Monitor: result is registered at the poll edge, sampled a quarter period later.
    always @(posedge clk) begin
        if (rst_n && poll_stb) begin
            exp_t e;
            #(CLK_P/4);
            if (exp_q.size() == 0) begin
                chk(1'b0, "queue empty", 0, 1);
            end else begin
                e = exp_q.pop_front();
                chk(call_o == e.call, {e.tag, " call"}, int'(call_o), int'(e.call));
                if (e.call) begin
                    chk(int'(src_o) == e.idx, {e.tag, " src"}, int'(src_o), e.idx);
                    chk(int'(lvl_o) == e.lvl, {e.tag, " lvl"}, int'(lvl_o), e.lvl);
                    chk(int'(vec_o) == 3 + 8 * e.idx, "R2 vec", int'(vec_o), 3 + 8 * e.idx);
                    @(posedge clk);
                    #(CLK_P/4);
                    chk(call_o == 1'b0, "R2 pulse width", int'(call_o), 0);
                end
            end
        end
    end

    task automatic chk_reset_outputs();
        chk(call_o == 1'b0, "R10 call", int'(call_o), 0);
        chk(src_o == '0, "R10 src", int'(src_o), 0);
        chk(lvl_o == '0, "R10 lvl", int'(lvl_o), 0);
        chk(vec_o == '0, "R10 vec", int'(vec_o), 0);
    endtask

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R2 actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_reset_outputs(); // R10

        // R1: raw flag present but never captured
        @(negedge clk); req = 12'h010;
        poll(1, 0, 0, 0, 0, 0, "R1 uncaptured");
        req = '0;
        // R1/R2: captured flag is served even after the raw flag drops
        capture(12'h010);
        poll(1, 0, 0, 1, 4, 0, "R2 basic call");
        capture(12'h010);
        poll(1, 0, 0, 0, 0, 0, "R5 same level in service");
        poll(1, 1, 0, 0, 0, 0, "R7 reti blocks");
        poll(0, 0, 0, 0, 0, 0, "R6 not last cycle");
        poll(1, 0, 1, 0, 0, 0, "R7 cfg write blocks");
        poll(1, 0, 0, 1, 4, 0, "R8 reti cleared level");
        poll(1, 1, 0, 0, 0, 0, "R8 return");

        // R4: fixed order at equal level
        capture(12'h228);
        poll(1, 0, 0, 1, 3, 0, "R4 tie 3/5/9");
        poll(1, 1, 0, 0, 0, 0, "R8 return");
        capture(12'h900);
        poll(1, 0, 0, 1, 8, 0, "R4 tie 8/11");
        poll(1, 1, 0, 0, 0, 0, "R8 return");

        // R3: level beats order
        prio_lo = 6'b100000; prio_hi = 6'b100000;
        capture(12'h801);
        poll(1, 0, 0, 1, 11, 3, "R3 level over order");
        // R5: lower level blocked while level 3 in service
        prio_hi = 6'b100001;
        capture(12'h001);
        poll(1, 0, 0, 0, 0, 0, "R5 lower level blocked");
        poll(1, 1, 0, 0, 0, 0, "R8 return");
        poll(1, 0, 0, 1, 0, 2, "R5 served after return");
        // R5: nesting by higher level
        capture(12'h800);
        poll(1, 0, 0, 1, 11, 3, "R5 nested higher level");
        poll(1, 1, 0, 0, 0, 0, "R8 return top");
        // R8: only level 3 cleared, level 2 still blocks
        prio_hi = 6'b100101;
        capture(12'h010);
        poll(1, 0, 0, 0, 0, 0, "R8 level 2 still in service");
        poll(1, 1, 0, 0, 0, 0, "R8 return");
        poll(1, 0, 0, 1, 4, 2, "R8 level 2 cleared");
        poll(1, 1, 0, 0, 0, 0, "R8 return");

        // R9: individual enable
        prio_hi = '0; prio_lo = 6'b000001; src_en = 12'hFFE;
        capture(12'h003);
        poll(1, 0, 0, 1, 1, 1, "R9 disabled source skipped");
        poll(1, 1, 0, 0, 0, 0, "R8 return");
        // R9: global enable
        src_en = 12'hFFF; glb_en = 1'b0;
        capture(12'h002);
        poll(1, 0, 0, 0, 0, 0, "R9 global enable off");
        glb_en = 1'b1;

        // R10: reset clears in-service state
        prio_lo = '0;
        capture(12'h004);
        poll(1, 0, 0, 1, 2, 0, "R2 call before reset");
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk_reset_outputs(); // R10
        rst_n = 1'b1;
        capture(12'h004);
        poll(1, 0, 0, 1, 2, 0, "R10 in-service cleared by reset");

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R2 all polls answered", exp_q.size(), 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule